// File: doc/BRIEF.md
# Microsequencer and Control Word Decoder

This block steps a small byte-wide processor through the microinstructions of each opcode. A 4-bit step counter and an 8-bit instruction register together address a microcode function. That function returns a 16-bit control word with packed fields. The fields are decoded into one-hot enable strobes for the address bus, the data-bus drivers and the data-bus loaders, and into stack and program-counter actions. A spare code in the driver field raises a jump request. The jump logic then loads the program counter only when the condition picked by the opcode's three low bits is true.

Step zero fetches an opcode whatever the instruction register holds. The word for step zero makes memory drive the bus at the program-counter address, loads the instruction register and advances the program counter. The block has no datapath or memory. It takes the opcode byte from the data bus and six comparison flags. It returns every control strobe and its current step.

The built-in microprogram groups opcodes by bits 7:3 into classes. Class 0 is a no-op. Class 1 is a conditional jump that reads a two-byte target. Class 2 pushes the A register. Class 3 is a long sequence that ends by counter wrap. Class 4 increments both address registers. Class 5 walks every code of every field. Every other class ends at step 1.

Top module: `useq_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, the step counter and instruction register clear. The first cycle after reset is step 0 with the fetch strobes.
- R2: At step 0 the outputs are: `addr_oe_o`=0001 (program counter drives), `pc_inc_o`=1, memory drives the data bus (`drv_oe_o[0]`), the instruction register loads (`ld_oe_o[0]`), and `alu_op_o`=0. This holds for any instruction register content.
- R3: The instruction register takes `opcode_in` only in a cycle whose loader code is 1. At step 0 this is always the case. Between those cycles it holds, so a later change on `opcode_in` does not change the steps that follow.
- R4: With no sequencer-reset code, the step advances by one each clock and wraps from 15 to 0.
- R5: Loader code 15 forces the step to 0 on the next clock.
- R6: Address field (word bits 5:4): code 0 enables the program counter, 1 the source address register, 2 the destination address register and 3 the stack pointer, on `addr_oe_o` bits 0 to 3. Exactly one bit is set.
- R7: Stack field (bits 7:6): 0 holds, 1 raises `sp_inc_o`, 2 raises `sp_dec_o`, and 3 raises `pc_inc_o`. At most one of them is set.
- R8: Driver field (bits 11:8): code n from 1 to 11 sets only `drv_oe_o[n-1]`. Code 12 sets `ar_inc_o`. Code 13 is a jump request. Codes 0, 14 and 15 drive nothing.
- R9: Loader field (bits 15:12): code n from 1 to 13 sets only `ld_oe_o[n-1]`. Code 14 sets `dr_inc_o`. Code 15 resets the sequencer.
- R10: `pc_load_o` is high only during a jump request. Opcode bits 2:0 select the condition: values 0 to 5 test `cond_in` bit 0 to 5, value 6 never jumps and value 7 always jumps.
- R11: Each opcode class runs the microprogram listed above. Its step words are as follows, written {loader, driver, stack, address, alu}. Class 1: {7,1,3,0,0}, {8,1,3,0,0}, {15,13,0,2,0}. Class 2: {0,0,2,0,0}, {4,2,0,3,0}, {15,0,0,0,0}. Class 3: step s is {0,0,0,0,s}. Class 4: {14,12,0,0,0}, {15,0,0,0,0}. Class 5: step s is {s,s,s mod 4,s mod 4,s}. All other classes: {15,0,0,0,0}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| opcode_in | input | 8 | Opcode byte from the data bus |
| cond_in | input | 6 | Comparison flags: zero, nonzero, negative, neg-or-zero, positive, zero-or-nonneg |
| step_o | output | 4 | Current microstep |
| alu_op_o | output | 4 | ALU operation field |
| addr_oe_o | output | 4 | One-hot address bus driver enable |
| sp_inc_o | output | 1 | Stack pointer increment |
| sp_dec_o | output | 1 | Stack pointer decrement |
| pc_inc_o | output | 1 | Program counter increment |
| drv_oe_o | output | 11 | One-hot data bus driver enables |
| ld_oe_o | output | 13 | One-hot data bus loader enables |
| ar_inc_o | output | 1 | Source address register increment |
| dr_inc_o | output | 1 | Destination address register increment |
| pc_load_o | output | 1 | Program counter load (jump taken) |

## Verification
The bench runs each of the 256 opcodes from fetch to its end. In every cycle it compares every strobe group with the word the requirements give for that class and step. Class 5 walks every code of every field, which separates a shifted or swapped decode line from a correct one. Class 3 runs with no reset code, so only a correct wrap returns it to fetch. In every jump-request cycle the bench sweeps all 64 flag patterns, which separates the six flag selects from the never and always codes for each of the eight select values. After fetch, the bench drives the complement of the opcode on `opcode_in` to show that the held register, and not the live input, steers the sequence.

// File: rtl/useq_pkg.sv
`timescale 1ns/1ps
package useq_pkg;
    localparam int STEP_W  = 4;
    localparam int OP_W    = 8;
    localparam int COND_N  = 6;
    localparam int FIELD_W = 4;
    localparam int DRV_N   = 11;
    localparam int LD_N    = 13;
    localparam int ADDR_N  = 4;
    localparam int STK_N   = 3;
    localparam int CSEL_W  = 3;
    localparam int CLASS_W = OP_W - CSEL_W;

    typedef logic [STEP_W-1:0]  step_t;
    typedef logic [OP_W-1:0]    op_t;
    typedef logic [FIELD_W-1:0] field_t;

    typedef enum logic [1:0] {ABUS_PC, ABUS_AR, ABUS_DR, ABUS_SP} abus_e;
    typedef enum logic [1:0] {STK_HOLD, STK_INC, STK_DEC, STK_PCINC} stk_e;

    // driver codes (1..11 are bus drivers, 12/13 reused)
    localparam field_t DRV_NONE  = 4'd0;
    localparam field_t DRV_MEM   = 4'd1;
    localparam field_t DRV_AREG  = 4'd2;
    localparam field_t DRV_ARINC = 4'd12;
    localparam field_t DRV_JUMP  = 4'd13;

    // loader codes (1..13 are bus loaders, 14/15 reused)
    localparam field_t LD_NONE   = 4'd0;
    localparam field_t LD_IR     = 4'd1;
    localparam field_t LD_MEM    = 4'd4;
    localparam field_t LD_TGTLO  = 4'd7;
    localparam field_t LD_TGTHI  = 4'd8;
    localparam field_t LD_DRINC  = 4'd14;
    localparam field_t LD_SEQRST = 4'd15;

    typedef struct packed {
        field_t ld;
        field_t drv;
        stk_e   stk;
        abus_e  abus;
        field_t alu;
    } cword_t;

    function automatic cword_t mk(field_t ld, field_t drv, stk_e stk, abus_e ab, field_t alu);
        cword_t w;
        w.ld = ld; w.drv = drv; w.stk = stk; w.abus = ab; w.alu = alu;
        return w;
    endfunction

    function automatic cword_t ucode(op_t op, step_t s);
        logic [CLASS_W-1:0] cls;
        cword_t done;
        cls  = op[OP_W-1:CSEL_W];
        done = mk(LD_SEQRST, DRV_NONE, STK_HOLD, ABUS_PC, '0);
        if (s == '0)
            return mk(LD_IR, DRV_MEM, STK_PCINC, ABUS_PC, '0);
        case (cls)
            5'd1: case (s)
                4'd1:    return mk(LD_TGTLO, DRV_MEM, STK_PCINC, ABUS_PC, '0);
                4'd2:    return mk(LD_TGTHI, DRV_MEM, STK_PCINC, ABUS_PC, '0);
                4'd3:    return mk(LD_SEQRST, DRV_JUMP, STK_HOLD, ABUS_DR, '0);
                default: return done;
            endcase
            5'd2: case (s)
                4'd1:    return mk(LD_NONE, DRV_NONE, STK_DEC, ABUS_PC, '0);
                4'd2:    return mk(LD_MEM, DRV_AREG, STK_HOLD, ABUS_SP, '0);
                default: return done;
            endcase
            5'd3:    return mk(LD_NONE, DRV_NONE, STK_HOLD, ABUS_PC, s);
            5'd4: case (s)
                4'd1:    return mk(LD_DRINC, DRV_ARINC, STK_HOLD, ABUS_PC, '0);
                default: return done;
            endcase
            5'd5:    return mk(s, s, stk_e'(s[1:0]), abus_e'(s[1:0]), s);
            default: return done;
        endcase
    endfunction
endpackage

// File: rtl/useq_dec.sv
`timescale 1ns/1ps
module useq_dec #(
    parameter int CODE_W = 4,
    parameter int N      = 4,
    parameter int BASE   = 0
) (
    input  logic [CODE_W-1:0] code,
    output logic [N-1:0]      hot
);
    for (genvar i = 0; i < N; i++) begin : g_line
        assign hot[i] = (code == CODE_W'(BASE + i));
    end
endmodule

// File: rtl/useq_jump.sv
`timescale 1ns/1ps
module useq_jump
    import useq_pkg::*;
(
    input  logic [COND_N-1:0] cond,
    input  logic [CSEL_W-1:0] sel,
    input  logic              req,
    output logic              load
);
    localparam logic [CSEL_W-1:0] SEL_NEVER  = CSEL_W'(COND_N);
    localparam logic [CSEL_W-1:0] SEL_ALWAYS = CSEL_W'(COND_N + 1);

    logic hit;
    always_comb begin
        if (sel == SEL_ALWAYS)      hit = 1'b1;
        else if (sel == SEL_NEVER)  hit = 1'b0;
        else                        hit = cond[sel];
    end
    assign load = req && hit;
endmodule

// File: rtl/useq_rom.sv
`timescale 1ns/1ps
module useq_rom
    import useq_pkg::*;
(
    input  op_t    ir,
    input  step_t  step,
    output cword_t word
);
    always_comb word = ucode(ir, step);
endmodule

// File: rtl/useq_seq.sv
`timescale 1ns/1ps
module useq_seq
    import useq_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  op_t   opcode,
    input  logic  ir_load,
    input  logic  seq_rst,
    output step_t step,
    output op_t   ir
);
    always_ff @(posedge clk) begin
        if (rst) begin
            step <= '0;
            ir   <= '0;
        end else begin
            step <= seq_rst ? '0 : step + 1'b1;
            if (ir_load) ir <= opcode;
        end
    end

    AST_IR_HOLD: assert property (@(posedge clk) disable iff (rst)
        !ir_load |=> $stable(ir)); // R3
    AST_STEP_ADVANCE: assert property (@(posedge clk) disable iff (rst)
        !seq_rst |=> step == STEP_W'($past(step) + 1)); // R4
    AST_SEQ_RESET: assert property (@(posedge clk) disable iff (rst)
        seq_rst |=> step == '0); // R5
endmodule

// File: rtl/useq_ctrl.sv
`timescale 1ns/1ps
module useq_ctrl
    import useq_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic [7:0]  opcode_in,
    input  logic [5:0]  cond_in,
    output logic [3:0]  step_o,
    output logic [3:0]  alu_op_o,
    output logic [3:0]  addr_oe_o,
    output logic        sp_inc_o,
    output logic        sp_dec_o,
    output logic        pc_inc_o,
    output logic [10:0] drv_oe_o,
    output logic [12:0] ld_oe_o,
    output logic        ar_inc_o,
    output logic        dr_inc_o,
    output logic        pc_load_o
);
    step_t  step;
    op_t    ir;
    cword_t word;
    logic   seq_rst, jump_req;
    logic [STK_N-1:0] stk_hot;

    useq_seq u_seq (
        .clk(clk), .rst(rst), .opcode(opcode_in),
        .ir_load(ld_oe_o[0]), .seq_rst(seq_rst),
        .step(step), .ir(ir)
    );

    useq_rom u_rom (.ir(ir), .step(step), .word(word));

    useq_dec #(.CODE_W(2), .N(ADDR_N), .BASE(0)) u_addr_dec (
        .code(word.abus), .hot(addr_oe_o));
    useq_dec #(.CODE_W(2), .N(STK_N), .BASE(1)) u_stk_dec (
        .code(word.stk), .hot(stk_hot));
    useq_dec #(.CODE_W(FIELD_W), .N(DRV_N), .BASE(1)) u_drv_dec (
        .code(word.drv), .hot(drv_oe_o));
    useq_dec #(.CODE_W(FIELD_W), .N(LD_N), .BASE(1)) u_ld_dec (
        .code(word.ld), .hot(ld_oe_o));

    assign sp_inc_o = stk_hot[0];
    assign sp_dec_o = stk_hot[1];
    assign pc_inc_o = stk_hot[2];
    assign ar_inc_o = (word.drv == DRV_ARINC);
    assign jump_req = (word.drv == DRV_JUMP);
    assign dr_inc_o = (word.ld == LD_DRINC);
    assign seq_rst  = (word.ld == LD_SEQRST);
    assign alu_op_o = word.alu;
    assign step_o   = step;

    useq_jump u_jump (
        .cond(cond_in), .sel(ir[CSEL_W-1:0]), .req(jump_req), .load(pc_load_o));

    AST_FETCH_AT_ZERO: assert property (@(posedge clk) disable iff (rst)
        step == '0 |-> ld_oe_o[0] && pc_inc_o && drv_oe_o[0] && addr_oe_o[0]); // R2
    AST_ADDR_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $countones(addr_oe_o) == 1); // R6
    AST_STACK_EXCL: assert property (@(posedge clk) disable iff (rst)
        $onehot0({sp_inc_o, sp_dec_o, pc_inc_o})); // R7
    AST_DRV_EXCL: assert property (@(posedge clk) disable iff (rst)
        $onehot0({drv_oe_o, ar_inc_o, jump_req})); // R8
    AST_LD_EXCL: assert property (@(posedge clk) disable iff (rst)
        $onehot0({ld_oe_o, dr_inc_o, seq_rst})); // R9
    AST_JUMP_GATED: assert property (@(posedge clk) disable iff (rst)
        !jump_req |-> !pc_load_o); // R10
endmodule

// File: tb/useq_ctrl_test.sv
`timescale 1ns/1ps
module useq_ctrl_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  opcode_in = '0;
    logic [5:0]  cond_in = '0;
    logic [3:0]  step_o, alu_op_o, addr_oe_o;
    logic        sp_inc_o, sp_dec_o, pc_inc_o, ar_inc_o, dr_inc_o, pc_load_o;
    logic [10:0] drv_oe_o;
    logic [12:0] ld_oe_o;

    int vectors = 0;
    int errors  = 0;
    bit done    = 1'b0;

    useq_ctrl uut (.*);

    always #5 clk = ~clk;

    task automatic chk(string tag, int unsigned act, int unsigned exp);
        vectors++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h (t=%0t)", tag, act, exp, $time);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    function automatic logic [15:0] w(int ld, int drv, int stk, int ab, int alu);
        return {4'(ld), 4'(drv), 2'(stk), 2'(ab), 4'(alu)};
    endfunction

    // expected control word, from the requirement tables
    function automatic logic [15:0] exp_word(logic [7:0] op, int s);
        int c = op[7:3];
        if (s == 0) return w(1, 1, 3, 0, 0);
        case (c)
            1: if (s == 1) return w(7, 1, 3, 0, 0);
               else if (s == 2) return w(8, 1, 3, 0, 0);
               else if (s == 3) return w(15, 13, 0, 2, 0);
            2: if (s == 1) return w(0, 0, 2, 0, 0);
               else if (s == 2) return w(4, 2, 0, 3, 0);
            3: return w(0, 0, 0, 0, s);
            4: if (s == 1) return w(14, 12, 0, 0, 0);
            5: return w(s, s, s % 4, s % 4, s);
            default: ;
        endcase
        return w(15, 0, 0, 0, 0);
    endfunction

    function automatic int unsigned hot(int code, int base, int n);
        if (code >= base && code < base + n) return 32'd1 << (code - base);
        return 0;
    endfunction

    task automatic check_step(logic [7:0] op, int s);
        logic [15:0] x;
        int ld, drv, stk, ab, sel;
        bit exp_load;
        x = exp_word(op, s);
        ld = x[15:12]; drv = x[11:8]; stk = x[7:6]; ab = x[5:4];
        sel = op[2:0];
        chk(s == 0 ? "R1/R4 step" : "R4/R5 step", step_o, s);
        if (s == 0)
            chk("R2 fetch", {ld_oe_o[0], drv_oe_o[0], pc_inc_o, addr_oe_o, alu_op_o},
                {1'b1, 1'b1, 1'b1, 4'b0001, 4'h0});
        chk(s == 1 ? "R3 alu" : "R11 alu", alu_op_o, x[3:0]);
        chk("R6 addr", addr_oe_o, 32'd1 << ab);
        chk("R7 stack", {sp_inc_o, sp_dec_o, pc_inc_o},
            {stk == 1, stk == 2, stk == 3});
        chk("R8 drv", {ar_inc_o, drv_oe_o}, {drv == 12, 11'(hot(drv, 1, 11))});
        chk(s == 1 ? "R3 ld" : "R9 ld", {dr_inc_o, ld_oe_o}, {ld == 14, 13'(hot(ld, 1, 13))});
        if (drv == 13) begin
            for (int c = 0; c < 64; c++) begin
                cond_in = 6'(c);
                #0.01;
                exp_load = (sel == 7) || (sel < 6 && c[sel]);
                chk("R10 jump", pc_load_o, exp_load);
            end
        end else begin
            cond_in = 6'h3F;
            #0.01;
            chk("R10 no request", pc_load_o, 0);
        end
    endtask

    task automatic run_op(logic [7:0] op);
        int s = 0;
        logic [15:0] x;
        opcode_in = op;
        do begin
            check_step(op, s);
            x = exp_word(op, s);
            tick();
            // after fetch, the held register must steer the sequence (R3)
            if (s == 0 && op[7:3] != 5'd5) opcode_in = ~op;
            s = (x[15:12] == 4'd15) ? 0 : (s + 1) % 16;
        end while (s != 0);
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) tick();
        rst = 1'b0;
        // R1: reset state gives step 0 and fetch
        check_step(8'h00, 0);
        for (int op = 0; op < 256; op++) run_op(8'(op));
        // R1: reset in mid-sequence of the long class
        opcode_in = 8'h1B;
        repeat (8) tick();
        chk("R4 mid long", step_o, 8);
        rst = 1'b1;
        tick();
        rst = 1'b0;
        chk("R1 step after reset", step_o, 0);
        check_step(8'h00, 0);
        run_op(8'h00);
        run_op(8'h2F);
        chk("R5 back to fetch", step_o, 0);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule